// File: doc/BRIEF.md
# Paged Translation DMA Engine

This block moves words between devices and system memory for several DMA channels. A device never sees physical memory. The engine walks the channel's logical byte range one page at a time. For each page it reads a translation entry from a table held in memory, then sends the data to the physical frame that the entry names. Software sets up the following through a simple register port:

- the table's base and size;
- for each channel, a control word, a byte count and a logical start address.

A device starts a transfer by presenting a request (channel, direction, byte length) on a valid/ready handshake. The engine first checks that the channel is enabled and that its programmed direction matches the request. A failed check raises a per-channel error flag in a shared error source register, and no memory access is made. A channel that passes has its length clipped to its byte count. When the transfer ends, the count is reduced by the bytes actually moved and a terminal-count flag is set.

Device data flows on two streams, both valid/ready. A word is taken on a cycle where both valid and ready are high. The engine raises `in_ready` only while it wants the next word to write to memory. When `out_valid` is high and `out_ready` is low, the engine holds `out_valid` and `out_data` unchanged. Memory is reached over a request/grant bus that moves one 32-bit word per grant. Transfers move whole words: the low two bits of the request length, the count and the start address are ignored.

Top module: `paged_dma`

## Requirements
- R1: After reset, every register reads zero, and `busy` and `mem_req` are low while `req_ready` is high.
- R2: Register map (the low three address bits must be zero for a hit):
  - global registers: table base at 0x000, table limit at 0x008, error source at 0x010;
  - channel n uses offsets 0x100+0x20*n plus a word offset: +0x00 reads zero, +0x08 is control, +0x10 is byte count, +0x18 is logical start address;
  - control bits: bit 0 enable, bit 1 memory-to-device, bit 8 terminal count, bit 9 channel error, bit 10 address error (cleared only).
- R3: Accepting a request clears control bits 10:8 of the requested channel before any other flag update.
- R4: A request to a disabled channel, or one whose direction (`req_to_dev`) differs from control bit 1, sets control bit 9 and error source bit n. It makes no memory access, leaves `busy` low and leaves the count unchanged.
- R5: The transfer length is the smaller of the request length and the channel count. At the end the count drops by the bytes moved and control bit 8 is set.
- R6: Before moving data in a page, the engine reads the frame word at (base + page index*8) masked to bits 30:0, then the owner word 4 bytes above it. The page index is the logical address divided by 4096.
- R7: Each data word goes to (frame + logical address mod 4096), with one bus access per word and addresses rising by 4.
- R8: When the logical address crosses into a new 4096-byte page, a fresh table entry is fetched before the next data access.
- R9: If the page index is at least limit/8, the transfer stops with no further access. The count drops only by the bytes already moved, and bit 8 is still set.
- R10: In memory-to-device transfers each word read from memory appears on `out_data`, in order, and stays stable while `out_ready` is low.
- R11: `busy` rises in the cycle after an accepted request that passes the checks and falls after the final count update. `req_ready` is high only when not busy.
- R12: Once `mem_req` is raised, it stays high with stable address, write flag and write data until `mem_gnt` is seen.
- R13: Writing the error source register clears the bits written as one. A new error set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_chan | input | 2 | Requested channel |
| req_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| req_len | input | 32 | Requested length in bytes |
| in_valid | input | 1 | Device write word valid |
| in_ready | output | 1 | Engine takes a device word |
| in_data | input | 32 | Device word to write to memory |
| out_valid | output | 1 | Word read from memory valid |
| out_ready | input | 1 | Device accepts the word |
| out_data | output | 32 | Word read from memory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access performed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| busy | output | 1 | A transfer is in progress |

## Verification
The assertions take three things for granted:
- the memory side grants only while `mem_req` is high and returns read data in the grant cycle;
- software does not rewrite a channel's registers while that channel is transferring;
- the table and frame addresses produced by the stimulus stay word aligned.

The bench grants from a memory model only in response to a request, with a rotating delay of zero to two cycles. It programs each channel only between transfers. It keeps the table base, the frames and the start addresses multiples of eight. Its device streams hold a word until the engine takes it.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int REG_AW = 10;
  localparam int DW     = 32;

  localparam logic [1:0] W_ZERO  = 2'd0;
  localparam logic [1:0] W_CTRL  = 2'd1;
  localparam logic [1:0] W_COUNT = 2'd2;
  localparam logic [1:0] W_ADDR  = 2'd3;

  localparam logic [7:0] G_BASE  = 8'h00;
  localparam logic [7:0] G_LIMIT = 8'h08;
  localparam logic [7:0] G_ERR   = 8'h10;

  localparam int B_EN   = 0;
  localparam int B_DIR  = 1;
  localparam int B_TC   = 8;
  localparam int B_MERR = 9;
  localparam int B_AERR = 10;

  localparam logic [31:0] ENTRY_MASK = 32'h7FFF_FFFF;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_ENT0, S_ENT1, S_GETW, S_MEM, S_PUT, S_DONE
  } pdma_state_e;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs import pdma_pkg::*; #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [DW-1:0]     tbl_base,
  output logic [DW-1:0]     tbl_limit,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    ch_dir,
  output logic [DW-1:0]     ch_count [NCH],
  output logic [DW-1:0]     ch_addr  [NCH],
  input  logic              st_valid,
  input  logic [CW-1:0]     st_chan,
  input  logic              err_valid,
  input  logic              done_valid,
  input  logic [CW-1:0]     done_chan,
  input  logic [DW-1:0]     done_moved
);
  logic          aligned, is_ch, is_glb;
  logic [2:0]    sel_chan;
  logic [1:0]    sel_word;
  logic [DW-1:0] ctrl_v [NCH];
  logic [NCH-1:0] err_q;

  assign aligned  = (reg_addr[2:0] == 3'd0);
  assign is_ch    = aligned && (reg_addr[9:8] == 2'b01);
  assign is_glb   = aligned && (reg_addr[9:8] == 2'b00);
  assign sel_chan = reg_addr[7:5];
  assign sel_word = reg_addr[4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base  <= '0;
      tbl_limit <= '0;
    end else if (reg_we && is_glb) begin
      if (reg_addr[7:0] == G_BASE)  tbl_base  <= reg_wdata;
      if (reg_addr[7:0] == G_LIMIT) tbl_limit <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else begin
      if (reg_we && is_glb && reg_addr[7:0] == G_ERR)
        err_q <= err_q & ~reg_wdata[NCH-1:0];
      if (err_valid)
        err_q[st_chan] <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          hit;
    logic [DW-1:0] ctrl_q, count_q, addr_q;
    assign hit = reg_we && is_ch && (sel_chan == 3'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q  <= '0;
        count_q <= '0;
        addr_q  <= '0;
      end else begin
        if (hit && sel_word == W_CTRL)  ctrl_q  <= reg_wdata;
        if (hit && sel_word == W_COUNT) count_q <= reg_wdata;
        if (hit && sel_word == W_ADDR)  addr_q  <= reg_wdata;
        if (st_valid && st_chan == CW'(c)) begin
          ctrl_q[B_AERR:B_TC] <= 3'b000;
          if (err_valid) ctrl_q[B_MERR] <= 1'b1;
        end
        if (done_valid && done_chan == CW'(c)) begin
          ctrl_q[B_TC] <= 1'b1;
          count_q      <= count_q - done_moved;
        end
      end
    end

    assign ctrl_v[c]   = ctrl_q;
    assign ch_en[c]    = ctrl_q[B_EN];
    assign ch_dir[c]   = ctrl_q[B_DIR];
    assign ch_count[c] = count_q;
    assign ch_addr[c]  = addr_q;

    // R5: without a software write the count can only shrink
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && sel_word == W_COUNT) |=> (count_q <= $past(count_q)));
  end

  always_comb begin
    reg_rdata = '0;
    if (is_glb) begin
      case (reg_addr[7:0])
        G_BASE:  reg_rdata = tbl_base;
        G_LIMIT: reg_rdata = tbl_limit;
        G_ERR:   reg_rdata = DW'(err_q);
        default: reg_rdata = '0;
      endcase
    end else if (is_ch && sel_chan < 3'(NCH)) begin
      case (sel_word)
        W_CTRL:  reg_rdata = ctrl_v[sel_chan[CW-1:0]];
        W_COUNT: reg_rdata = ch_count[sel_chan[CW-1:0]];
        W_ADDR:  reg_rdata = ch_addr[sel_chan[CW-1:0]];
        default: reg_rdata = '0;
      endcase
    end
  end

  // R13: error bits only clear through a register write
  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> (($past(err_q) & ~err_q) == '0));
endmodule

// File: rtl/pdma_xlate.sv
module pdma_xlate import pdma_pkg::*; #(
  parameter int PAGE_BITS = 12
) (
  input  logic [DW-1:0] laddr,
  input  logic [DW-1:0] tbl_base,
  input  logic [DW-1:0] tbl_limit,
  input  logic [DW-1:0] frame,
  output logic          over_limit,
  output logic          last_in_page,
  output logic [DW-1:0] entry_addr,
  output logic [DW-1:0] owner_addr,
  output logic [DW-1:0] phys_addr
);
  localparam logic [DW-1:0] OFS_MASK = DW'((64'd1 << PAGE_BITS) - 1);

  logic [DW-1:0] page_idx, n_entries, raw;

  always_comb begin
    page_idx     = laddr >> PAGE_BITS;
    n_entries    = tbl_limit >> 3;
    over_limit   = (page_idx >= n_entries);
    raw          = tbl_base + (page_idx << 3);
    entry_addr   = raw & ENTRY_MASK;
    owner_addr   = (raw + 32'd4) & ENTRY_MASK;
    phys_addr    = frame + (laddr & OFS_MASK);
    last_in_page = &laddr[PAGE_BITS-1:2];
  end
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl import pdma_pkg::*; #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CW-1:0]  req_chan,
  input  logic           req_to_dev,
  input  logic [DW-1:0]  req_len,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_dir,
  input  logic [DW-1:0]  ch_count [NCH],
  input  logic [DW-1:0]  ch_addr  [NCH],
  output logic [DW-1:0]  cur_laddr,
  output logic [DW-1:0]  cur_frame,
  input  logic           over_limit,
  input  logic           last_in_page,
  input  logic [DW-1:0]  entry_addr,
  input  logic [DW-1:0]  owner_addr,
  input  logic [DW-1:0]  phys_addr,
  output logic           st_valid,
  output logic [CW-1:0]  st_chan,
  output logic           err_valid,
  output logic           done_valid,
  output logic [CW-1:0]  done_chan,
  output logic [DW-1:0]  done_moved,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy
);
  pdma_state_e   st;
  logic [CW-1:0] chan_q;
  logic          dir_q;
  logic [DW-1:0] remain_q, moved_q, laddr_q, frame_q, buf_q;
  logic          fire, chan_ok, word_done;
  logic [DW-1:0] len_w, cnt_w, eff_len;

  always_comb begin
    req_ready  = (st == S_IDLE);
    fire       = req_valid && req_ready;
    chan_ok    = ch_en[req_chan] && (ch_dir[req_chan] == req_to_dev);
    len_w      = req_len & ~DW'(3);
    cnt_w      = ch_count[req_chan] & ~DW'(3);
    eff_len    = (len_w < cnt_w) ? len_w : cnt_w;
    st_valid   = fire;
    st_chan    = req_chan;
    err_valid  = fire && !chan_ok;
    done_valid = (st == S_DONE);
    done_chan  = chan_q;
    done_moved = moved_q;
    in_ready   = (st == S_GETW);
    out_valid  = (st == S_PUT);
    out_data   = buf_q;
    mem_req    = (st == S_ENT0) || (st == S_ENT1) || (st == S_MEM);
    mem_we     = (st == S_MEM) && !dir_q;
    mem_wdata  = buf_q;
    case (st)
      S_ENT0:  mem_addr = entry_addr;
      S_ENT1:  mem_addr = owner_addr;
      default: mem_addr = phys_addr;
    endcase
    busy       = (st != S_IDLE);
    word_done  = (st == S_MEM && mem_gnt && !dir_q) || (st == S_PUT && out_ready);
    cur_laddr  = laddr_q;
    cur_frame  = frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      chan_q   <= '0;
      dir_q    <= 1'b0;
      remain_q <= '0;
      moved_q  <= '0;
      laddr_q  <= '0;
      frame_q  <= '0;
      buf_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (fire && chan_ok) begin
          chan_q   <= req_chan;
          dir_q    <= req_to_dev;
          remain_q <= eff_len;
          moved_q  <= '0;
          laddr_q  <= ch_addr[req_chan] & ~DW'(3);
          st       <= (eff_len == '0) ? S_DONE : S_CHECK;
        end
        S_CHECK: st <= over_limit ? S_DONE : S_ENT0;
        S_ENT0: if (mem_gnt) begin
          frame_q <= mem_rdata;
          st      <= S_ENT1;
        end
        S_ENT1: if (mem_gnt) st <= dir_q ? S_MEM : S_GETW;
        S_GETW: if (in_valid) begin
          buf_q <= in_data;
          st    <= S_MEM;
        end
        S_MEM: if (mem_gnt && dir_q) begin
          buf_q <= mem_rdata;
          st    <= S_PUT;
        end
        S_DONE: st <= S_IDLE;
        default: ;
      endcase
      if (word_done) begin
        laddr_q  <= laddr_q + DW'(4);
        remain_q <= remain_q - DW'(4);
        moved_q  <= moved_q + DW'(4);
        if (remain_q == DW'(4))  st <= S_DONE;
        else if (last_in_page)   st <= S_CHECK;
        else                     st <= dir_q ? S_MEM : S_GETW;
      end
    end
  end

  // R12: an access is held until granted
  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R10: output word held under back-pressure
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R6: table reads never reach above the 31-bit window
  assert_entry_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (st == S_ENT0 || st == S_ENT1) |-> !mem_addr[31]);
  // R4: a rejected request leaves the engine idle with no access
  assert_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !busy && !mem_req);
  // R9: a page past the limit is never touched
  assert_limit_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK) && over_limit |=> !mem_req && done_valid);
endmodule

// File: rtl/paged_dma.sv
module paged_dma import pdma_pkg::*; #(
  parameter int NCH       = 4,
  parameter int PAGE_BITS = 12,
  localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CW-1:0]     req_chan,
  input  logic              req_to_dev,
  input  logic [DW-1:0]     req_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy
);
  logic [DW-1:0]  tbl_base, tbl_limit;
  logic [NCH-1:0] ch_en, ch_dir;
  logic [DW-1:0]  ch_count [NCH];
  logic [DW-1:0]  ch_addr  [NCH];
  logic           st_valid, err_valid, done_valid;
  logic [CW-1:0]  st_chan, done_chan;
  logic [DW-1:0]  done_moved, cur_laddr, cur_frame;
  logic           over_limit, last_in_page;
  logic [DW-1:0]  entry_addr, owner_addr, phys_addr;

  pdma_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .ch_en(ch_en), .ch_dir(ch_dir), .ch_count(ch_count), .ch_addr(ch_addr),
    .st_valid(st_valid), .st_chan(st_chan), .err_valid(err_valid),
    .done_valid(done_valid), .done_chan(done_chan), .done_moved(done_moved)
  );

  pdma_xlate #(.PAGE_BITS(PAGE_BITS)) u_xlate (
    .laddr(cur_laddr), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .frame(cur_frame), .over_limit(over_limit), .last_in_page(last_in_page),
    .entry_addr(entry_addr), .owner_addr(owner_addr), .phys_addr(phys_addr)
  );

  pdma_ctrl #(.NCH(NCH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_to_dev(req_to_dev), .req_len(req_len),
    .ch_en(ch_en), .ch_dir(ch_dir), .ch_count(ch_count), .ch_addr(ch_addr),
    .cur_laddr(cur_laddr), .cur_frame(cur_frame),
    .over_limit(over_limit), .last_in_page(last_in_page),
    .entry_addr(entry_addr), .owner_addr(owner_addr), .phys_addr(phys_addr),
    .st_valid(st_valid), .st_chan(st_chan), .err_valid(err_valid),
    .done_valid(done_valid), .done_chan(done_chan), .done_moved(done_moved),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .busy(busy)
  );
endmodule

// File: tb/paged_dma_bench.sv
module paged_dma_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req_valid = 1'b0, req_ready, req_to_dev = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [31:0] req_len = '0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] in_data = '0, out_data;
  logic        mem_req, mem_we, mem_gnt = 1'b0, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  paged_dma u_paged_dma (.*);

  always #4 clk = ~clk;

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; string req; } acc_t;
  acc_t        exp_q[$];
  logic [31:0] dev_in[$];
  logic [31:0] exp_out[$];
  logic [31:0] mem [logic [31:0]];
  int total = 0, bad = 0;
  int wcnt = 0, gdelay = 0, tick = 0;
  logic [31:0] first_addr = '0;
  logic in_fire = 1'b0, out_fire = 1'b0;
  logic [31:0] out_cap = '0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push(logic we, logic [31:0] a, logic [31:0] d, string r);
    acc_t x; x.we = we; x.addr = a; x.data = d; x.req = r;
    exp_q.push_back(x);
  endtask

  always @(posedge clk) begin
    in_fire  <= in_valid && in_ready;
    out_fire <= out_valid && out_ready;
    out_cap  <= out_data;
  end

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    tick++;
    mem_gnt = 1'b0;
    if (rst_n && mem_req) begin
      if (wcnt == 0) first_addr = mem_addr;
      if (wcnt >= gdelay) begin
        acc_t e;
        chk("R12", mem_addr, first_addr);
        mem_gnt = 1'b1;
        wcnt = 0;
        gdelay = (gdelay + 1) % 3;
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        if (exp_q.size() == 0) begin
          chk("R4", mem_addr, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk(e.req, {31'd0, mem_we}, {31'd0, e.we});
          chk(e.req, mem_addr, e.addr);
          if (e.we) chk(e.req, mem_wdata, e.data);
        end
      end else begin
        wcnt++;
      end
    end
    if (in_fire && dev_in.size() > 0) void'(dev_in.pop_front());
    in_valid = dev_in.size() > 0;
    in_data  = (dev_in.size() > 0) ? dev_in[0] : 32'h0;
    if (out_fire) begin
      if (exp_out.size() == 0) chk("R10", out_cap, 32'hDEAD_DEAD);
      else chk("R10", out_cap, exp_out.pop_front());
    end
    out_ready = (tick % 3) != 0;
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rchk(string r, logic [9:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(r, v, exp);
  endtask

  task automatic do_req(logic [1:0] ch, logic dir, logic [31:0] len);
    @(negedge clk); req_valid = 1'b1; req_chan = ch; req_to_dev = dir; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [9:0] cha(int ch, int w);
    return 10'(32'h100 + ch * 32'h20 + w * 8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      mem[32'h2000 + 8*k] = 32'h0010_0000 + 32'h1000 * k;
      mem[32'h2004 + 8*k] = 32'hCAFE_0000 + k;
    end
    mem[32'h0010_2010] = 32'hB000_0010;
    mem[32'h0010_2014] = 32'hB000_0014;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {31'd0, busy}, 32'd0);
    chk("R1", {31'd0, mem_req}, 32'd0);
    chk("R1", {31'd0, req_ready}, 32'd1);
    rchk("R1", cha(0, 2), 32'd0);
    rchk("R1", 10'h010, 32'd0);

    wr(10'h000, 32'h8000_2000);
    wr(10'h008, 32'h20);
    rchk("R2", 10'h000, 32'h8000_2000);
    rchk("R2", 10'h008, 32'h20);

    // A: device to memory, crossing a page
    wr(cha(0,1), 32'h1); wr(cha(0,2), 32'h100); wr(cha(0,3), 32'h0FF8);
    rchk("R2", cha(0,3), 32'h0FF8);
    rchk("R2", cha(0,0), 32'h0);
    push(0, 32'h2000, 0, "R6"); push(0, 32'h2004, 0, "R6");
    push(1, 32'h0010_0FF8, 32'hA000_0001, "R7"); push(1, 32'h0010_0FFC, 32'hA000_0002, "R7");
    push(0, 32'h2008, 0, "R8"); push(0, 32'h200C, 0, "R8");
    push(1, 32'h0010_1000, 32'hA000_0003, "R8"); push(1, 32'h0010_1004, 32'hA000_0004, "R7");
    for (int i = 1; i <= 4; i++) dev_in.push_back(32'hA000_0000 + i);
    do_req(2'd0, 1'b0, 32'd16);
    chk("R11", {31'd0, busy}, 32'd1);
    chk("R11", {31'd0, req_ready}, 32'd0);
    wait_idle();
    chk("R11", {31'd0, busy}, 32'd0);
    chk("R7", exp_q.size(), 0);
    rchk("R5", cha(0,2), 32'hF0);
    rchk("R5", cha(0,1), 32'h101);

    // B: memory to device, clipped by count, with back-pressure
    wr(cha(1,1), 32'h3); wr(cha(1,2), 32'h8); wr(cha(1,3), 32'h2010);
    push(0, 32'h2010, 0, "R6"); push(0, 32'h2014, 0, "R6");
    push(0, 32'h0010_2010, 0, "R7"); push(0, 32'h0010_2014, 0, "R7");
    exp_out.push_back(32'hB000_0010); exp_out.push_back(32'hB000_0014);
    do_req(2'd1, 1'b1, 32'd64);
    wait_idle();
    chk("R10", exp_out.size(), 0);
    chk("R5", exp_q.size(), 0);
    rchk("R5", cha(1,2), 32'h0);
    rchk("R5", cha(1,1), 32'h103);

    // C: disabled channel, then direction mismatch
    do_req(2'd2, 1'b0, 32'd8);
    chk("R4", {31'd0, busy}, 32'd0);
    wait_idle();
    rchk("R4", cha(2,1), 32'h200);
    rchk("R4", 10'h010, 32'h4);
    do_req(2'd1, 1'b0, 32'd8);
    wait_idle();
    rchk("R4", cha(1,1), 32'h203);
    rchk("R4", cha(1,2), 32'h0);
    rchk("R4", 10'h010, 32'h6);
    wr(10'h010, 32'h4);
    rchk("R13", 10'h010, 32'h2);

    // D: limit abort mid-transfer, flags preset
    wr(cha(3,1), 32'h701); wr(cha(3,2), 32'h40); wr(cha(3,3), 32'h3FF8);
    push(0, 32'h2018, 0, "R6"); push(0, 32'h201C, 0, "R6");
    push(1, 32'h0010_3FF8, 32'hD000_0001, "R9"); push(1, 32'h0010_3FFC, 32'hD000_0002, "R9");
    dev_in.push_back(32'hD000_0001); dev_in.push_back(32'hD000_0002);
    do_req(2'd3, 1'b0, 32'd32);
    wait_idle();
    chk("R9", exp_q.size(), 0);
    rchk("R9", cha(3,2), 32'h38);
    rchk("R3", cha(3,1), 32'h101);

    // E: first page already past the limit
    wr(cha(0,1), 32'h201); wr(cha(0,3), 32'h5000);
    do_req(2'd0, 1'b0, 32'd8);
    wait_idle();
    rchk("R9", cha(0,2), 32'hF0);
    rchk("R3", cha(0,1), 32'h101);
    rchk("R13", 10'h010, 32'h2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule